// File: doc/BRIEF.md
# Two-Register I2C Target with Pin-Selected Address

This block is an I2C target that lets a bus master configure a power-output controller and read its diagnostic flags. It keeps two registers. The register at pointer 0x0 is a read-only snapshot of the diagnostic inputs. The register at pointer 0x1 is a read/write control byte. The control byte drives a 3-bit output-level code and a compensation-mode bit. A level code of zero means standby. SCL and SDA pass through a multi-stage synchronizer and are sampled on a system clock that runs at least eight times faster than SCL. The block pulls SDA low only through an output-enable, so the pad stays open-drain.

A write transaction carries three things in order: the address byte with R/W low, a register pointer, and one or more data bytes. To read, the master first sets the pointer in a short write transaction and ends it with STOP. It then opens a new transaction with R/W high. The target returns the addressed byte and then keeps going through the registers for as long as the master acknowledges. While the undervoltage input is high, the target stays off the bus entirely and the control byte is forced to zero.

Top module: `i2c_regpair_target`

## Requirements
- R1: The target answers only to the 7-bit address 0001000 when `addr_sel` is 0 and to 0001001 when `addr_sel` is 1. The R/W bit is the LSB of the address byte. A byte with any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: For each byte it accepts (address, pointer, data), the target pulls SDA low during the ninth SCL clock. It changes `sda_oe` only while SCL is low.
- R3: A data byte written while the pointer is 0x01 updates the control byte. Bits 2:0 go to `level_sel` and bit 3 goes to `comp_mode`. Bits 7:4 are stored as 0, so they always read back as 0.
- R4: A data byte written while the pointer is 0x00 or any value of 0x02 and above is acknowledged and has no effect. When several data bytes follow one pointer, each one goes to that same pointer, and the last one wins.
- R5: In a read, each byte is sent MSB first. Pointer 0x00 returns `status_in` zero-extended to 8 bits. Pointer 0x01 returns the stored control byte. Any other pointer returns 0x00.
- R6: After each byte the master acknowledges, the pointer advances. 0x00 goes to 0x01, and 0x01 or any larger value goes to 0x00. The next byte then comes from the new pointer. The pointer keeps its value across transactions.
- R7: After the master does not acknowledge a read byte, the target releases SDA. It ignores all SCL activity until the next START.
- R8: `status_rd_strobe` is a one-cycle pulse each time the status byte is loaded for sending.
- R9: While `uvlo` is 1, the target never pulls SDA low and the control byte (and so `level_sel` and `comp_mode`) is 0. The byte stays 0 after `uvlo` falls until it is written again.
- R10: After reset, `sda_oe`, `level_sel`, `comp_mode` and `status_rd_strobe` are 0 and the pointer is 0x00.
- R11: A START seen partway through a byte abandons that byte and begins receiving a new address byte. A data byte cut short this way leaves the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Selects the LSB of the target address |
| uvlo | input | 1 | Undervoltage flag: silences the target and clears the control byte |
| status_in | input | STAT_W | Diagnostic flags returned at pointer 0x00 |
| level_sel | output | LVL_W | Output-level code, 0 = standby |
| comp_mode | output | 1 | Compensation-mode select |
| status_rd_strobe | output | 1 | One-cycle pulse when the status byte is fetched for a read |

## Verification
The synchronizer adds two cycles of latency and the engine adds one registered stage. As a result, `sda_oe` responds about three system clocks after the SCL edge that causes the change, and a new control value reaches `level_sel` about four clocks after the falling SCL edge that ends the data byte. The bench master holds each SCL phase for twelve clocks and samples SDA halfway through the high phase, so every acknowledge and read bit is read well after it has settled. Control outputs and strobe counts are checked only after a STOP has completed, and undervoltage effects two clocks after `uvlo` changes.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} rp_state_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rp_kind_e;
  localparam logic [7:0] PTR_STATUS = 8'h00;
  localparam logic [7:0] PTR_CTRL   = 8'h01;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'b0001000,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo,
  input  logic              addr_sel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic [7:0]        ptr,
  output logic              rd_req,
  output logic              wr_en,
  output logic [CTRL_W-1:0] wr_data,
  output logic              sda_oe
);
  rp_state_e  state;
  rp_kind_e   kind;
  logic [3:0] bitcnt;
  logic [7:0] rxsh, txsh;
  logic       rd_mode;
  logic [6:0] my_addr;

  assign my_addr = {ADDR_BASE[6:1], addr_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; kind <= K_ADDR; bitcnt <= '0; rxsh <= '0; txsh <= '0;
      sda_oe <= 1'b0; rd_mode <= 1'b0; ptr <= PTR_STATUS;
      wr_en <= 1'b0; wr_data <= '0; rd_req <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (uvlo) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_det) begin
        state <= ST_RX; kind <= K_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              rxsh   <= {rxsh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (rxsh[7:1] == my_addr) begin
                    rd_mode <= rxsh[0]; sda_oe <= 1'b1; state <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr <= rxsh; sda_oe <= 1'b1; state <= ST_ACK;
                end
                default: begin
                  if (ptr == PTR_CTRL) begin
                    wr_en <= 1'b1; wr_data <= rxsh[CTRL_W-1:0];
                  end
                  sda_oe <= 1'b1; state <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rd_mode && kind == K_ADDR) begin
                txsh <= rd_data; sda_oe <= ~rd_data[7]; rd_req <= 1'b1;
                bitcnt <= '0; state <= ST_TX;
              end else begin
                sda_oe <= 1'b0; state <= ST_RX;
                kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0; state <= ST_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_s) ptr <= (ptr == PTR_STATUS) ? PTR_CTRL : PTR_STATUS;
              else        state <= ST_IDLE;
            end else if (scl_fall) begin
              txsh <= rd_data; sda_oe <= ~rd_data[7]; rd_req <= 1'b1;
              bitcnt <= '0; state <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: no pull on SDA in the cycle after undervoltage was seen
  assert_uvlo_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(uvlo) |-> !sda_oe);

  // R2: the pull on SDA only toggles while the synchronized SCL was low
  assert_sda_on_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(uvlo) && !$past(rst)) |-> !$past(scl_s));
endmodule

// File: rtl/i2c_rp_regs.sv
module i2c_rp_regs
  import i2c_rp_pkg::*;
#(
  parameter int STAT_W = 5,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [7:0]        rd_ptr,
  input  logic              rd_req,
  input  logic [STAT_W-1:0] status_in,
  output logic [7:0]        rd_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              status_rd_strobe
);
  always_ff @(posedge clk) begin
    if (rst || uvlo)  ctrl_q <= '0;
    else if (wr_en)   ctrl_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) status_rd_strobe <= 1'b0;
    else     status_rd_strobe <= rd_req && (rd_ptr == PTR_STATUS);
  end

  always_comb begin
    case (rd_ptr)
      PTR_STATUS: rd_data = 8'(status_in);
      PTR_CTRL:   rd_data = 8'(ctrl_q);
      default:    rd_data = 8'h00;
    endcase
  end

  // R9: control byte reads zero after a cycle of undervoltage
  assert_ctrl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(uvlo) |-> (ctrl_q == '0));

  // R4: without a write strobe from the engine the control byte keeps its value
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(uvlo)) |-> $stable(ctrl_q));

  // R8: the status fetch strobe never lasts two cycles
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    status_rd_strobe |=> !status_rd_strobe);
endmodule

// File: rtl/i2c_regpair_target.sv
module i2c_regpair_target #(
  parameter logic [6:0] ADDR_BASE   = 7'b0001000,
  parameter int         SYNC_STAGES = 2,
  parameter int         STAT_W      = 5,
  parameter int         LVL_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic              uvlo,
  input  logic [STAT_W-1:0] status_in,
  output logic [LVL_W-1:0]  level_sel,
  output logic              comp_mode,
  output logic              status_rd_strobe
);
  localparam int CTRL_W = LVL_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, rd_data;
  logic rd_req, wr_en;
  logic [CTRL_W-1:0] wr_data, ctrl_q;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_rp_engine #(.ADDR_BASE(ADDR_BASE), .CTRL_W(CTRL_W)) u_engine (
    .clk(clk), .rst(rst), .uvlo(uvlo), .addr_sel(addr_sel),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .ptr(ptr), .rd_req(rd_req), .wr_en(wr_en), .wr_data(wr_data),
    .sda_oe(sda_oe));

  i2c_rp_regs #(.STAT_W(STAT_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst(rst), .uvlo(uvlo), .wr_en(wr_en), .wr_data(wr_data),
    .rd_ptr(ptr), .rd_req(rd_req), .status_in(status_in),
    .rd_data(rd_data), .ctrl_q(ctrl_q), .status_rd_strobe(status_rd_strobe));

  assign level_sel = ctrl_q[LVL_W-1:0];
  assign comp_mode = ctrl_q[CTRL_W-1];
endmodule

// File: tb/i2c_regpair_target_test.sv
module i2c_regpair_target_test;
  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [6:0] A0 = 7'b0001000;
  localparam logic [6:0] A1 = 7'b0001001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, uvlo = 1'b0;
  logic [4:0] status_in = 5'h00;
  logic sda_oe, comp_mode, status_rd_strobe;
  logic [2:0] level_sel;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  i2c_regpair_target uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .uvlo(uvlo), .status_in(status_in),
    .level_sel(level_sel), .comp_mode(comp_mode),
    .status_rd_strobe(status_rd_strobe));

  always @(posedge clk) if (!rst && status_rd_strobe) strobes++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    end
  endtask

  // sends a byte; scoreboard expects 1 for an acknowledge, 0 for none
  task automatic tx_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    send_bits(b, 8);
    expect_item({7'd0, exp_ack}, tag);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2); scl_m = 1'b0; wt(Q);
    obs_q.push_back({7'd0, ack});
  endtask

  task automatic rx_byte(input logic [7:0] exp, input logic m_ack, input string tag);
    logic [7:0] v = '0;
    expect_item(exp, tag);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2);
      v = {v[6:0], sda_line};
      wt(H/2); scl_m = 1'b0; wt(Q);
    end
    obs_q.push_back(v);
    sda_m = ~m_ack; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_tr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, input string tag);
    bus_start();
    tx_byte({a, 1'b0}, 1'b1, {tag, " addr ack"});
    tx_byte(p, 1'b1, {tag, " ptr ack"});
    tx_byte(d, 1'b1, {tag, " data ack"});
    bus_stop();
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p);
    bus_start();
    tx_byte({a, 1'b0}, 1'b1, "R1 ptr-set addr ack");
    tx_byte(p, 1'b1, "R2 ptr-set ptr ack");
    bus_stop();
  endtask

  task automatic read_open(input logic [6:0] a);
    bus_start();
    tx_byte({a, 1'b1}, 1'b1, "R5 read addr ack");
  endtask

  // scoreboard monitor
  initial begin
    logic [7:0] o, e;
    string t;
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, o}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    wt(5); rst = 1'b0; wt(3);
    // R10 reset state
    check("R10 sda_oe after reset", sda_oe, 0);
    check("R10 level_sel after reset", level_sel, 0);
    check("R10 comp_mode after reset", comp_mode, 0);
    check("R10 strobe after reset", status_rd_strobe, 0);

    // R3 write control byte, reserved bits dropped
    write_tr(A0, 8'h01, 8'hFB, "R3");
    wt(4);
    check("R3 level_sel", level_sel, 3'b011);
    check("R3 comp_mode", comp_mode, 1);
    set_ptr(A0, 8'h01);
    read_open(A0);
    rx_byte(8'h0B, 1'b0, "R3 readback reserved zero");
    bus_stop();

    // R1 wrong address gets no acknowledge
    bus_start();
    tx_byte({A1, 1'b0}, 1'b0, "R1 foreign addr nack");
    tx_byte(8'h01, 1'b0, "R1 rest ignored");
    bus_stop();
    check("R1 level unchanged", level_sel, 3'b011);

    // R4 writes to pointer 0 and 5 are ignored
    write_tr(A0, 8'h00, 8'h55, "R4 ptr0");
    write_tr(A0, 8'h05, 8'h52, "R4 ptr5");
    wt(4);
    check("R4 level after ignored writes", level_sel, 3'b011);
    check("R4 comp after ignored writes", comp_mode, 1);

    // R5 R6 R8 status read with auto-advance and wrap
    status_in = 5'h15;
    set_ptr(A0, 8'h00);
    s0 = strobes;
    read_open(A0);
    rx_byte(8'h15, 1'b1, "R5 status byte");
    rx_byte(8'h0B, 1'b1, "R6 advance to ctrl");
    rx_byte(8'h15, 1'b0, "R6 wrap to status");
    // R7 after NACK the target stays off the bus without a START
    tx_byte({A0, 1'b0}, 1'b0, "R7 ignored after nack");
    check("R7 sda released", sda_oe, 0);
    bus_stop();
    wt(4);
    check("R8 status strobes", strobes - s0, 2);

    // R6 pointer above 1 reads zero then wraps to status
    set_ptr(A0, 8'h07);
    s0 = strobes;
    read_open(A0);
    rx_byte(8'h00, 1'b1, "R6 out-of-range reads zero");
    rx_byte(8'h15, 1'b0, "R6 wrap from high ptr");
    bus_stop();
    wt(4);
    check("R8 strobe after wrap", strobes - s0, 1);

    // R1 alternate address with addr_sel high
    addr_sel = 1'b1;
    bus_start();
    tx_byte({A0, 1'b0}, 1'b0, "R1 base addr nack when sel=1");
    bus_stop();
    bus_start();
    tx_byte({A1, 1'b0}, 1'b1, "R1 alt addr ack");
    tx_byte(8'h01, 1'b1, "R4 multi ptr ack");
    tx_byte(8'h02, 1'b1, "R4 multi data1 ack");
    tx_byte(8'hF6, 1'b1, "R4 multi data2 ack");
    bus_stop();
    wt(4);
    check("R4 last byte wins level", level_sel, 3'b110);
    check("R4 last byte wins comp", comp_mode, 0);

    // R9 undervoltage
    uvlo = 1'b1; wt(2);
    check("R9 level cleared", level_sel, 0);
    bus_start();
    tx_byte({A1, 1'b0}, 1'b0, "R9 no ack in uvlo");
    tx_byte(8'h01, 1'b0, "R9 ptr no ack");
    tx_byte(8'h07, 1'b0, "R9 data no ack");
    bus_stop();
    check("R9 level still zero", level_sel, 0);
    uvlo = 1'b0; wt(2);
    check("R9 level zero after uvlo", level_sel, 0);

    // R11 START mid-byte abandons the data byte
    write_tr(A1, 8'h01, 8'h05, "R11 setup");
    bus_start();
    tx_byte({A1, 1'b0}, 1'b1, "R11 addr ack");
    tx_byte(8'h01, 1'b1, "R11 ptr ack");
    send_bits(8'hF0, 4);
    bus_start();
    tx_byte({A1, 1'b1}, 1'b1, "R11 restart addr ack");
    rx_byte(8'h05, 1'b0, "R11 ctrl unchanged");
    bus_stop();
    check("R11 level unchanged", level_sel, 3'b101);

    wt(20);
    if (exp_q.size() != 0 || obs_q.size() != 0)
      check("R2 scoreboard drained", obs_q.size(), exp_q.size());
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule